// File: doc/BRIEF.md
# Sleep Mode Wake-Up Controller

This block puts a bus controller into a low-power sleep state and brings it back out. While the software-owned sleep-enable bit is low, the block stays in normal operation. In that state the oscillator enable is high and the activity inhibit is low. Once the sleep bit has been seen high on two consecutive clock edges, the block raises the inhibit, which stops all other logic. One cycle later it drops the oscillator enable.

Three sources can end sleep:

- the reset input, which acts asynchronously;
- an active-low chip select held active;
- a falling edge, from recessive 1 to dominant 0, on either of two redundant receive lines.

The chip select and both receive lines pass through synchronisers before use. A receive line that is already low when sleep begins does not wake the block. When a wake is taken, the block pulses a one-cycle wake indication. The register that holds the sleep bit uses this pulse to clear the bit. While the pulse is high, the block refuses to re-enter sleep.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While rst_n is low, osc_en_o is 1, inhibit_o is 0 and wake_o is 0.
- R2: With sleep_en_i at 0, inhibit_o stays 0 and osc_en_o stays 1. Chip-select activity and receive-line falling edges then produce no wake_o pulse.
- R3: Suppose sleep_en_i is high at the clock edges E1 and E2. Then inhibit_o is 1 after E2 while osc_en_o is still 1, and osc_en_o is 0 after E3.
- R4: A sleep_en_i high for only one clock edge does not start sleep.
- R5: In sleep, cs_n_i driven low before edge E1 causes the following after E3: wake_o is 1, inhibit_o is 0 and osc_en_o is 1. Before E3 the block is still inhibited. wake_o is 0 again after E4.
- R6: In sleep, a 1-to-0 change on rx0_i wakes the block with the same timing as R5.
- R7: In sleep, a 1-to-0 change on rx1_i wakes the block with the same timing as R5.
- R8: In sleep, a receive line that is already 0, or that rises from 0 to 1, does not wake the block.
- R9: Pulling rst_n low during sleep sets osc_en_o to 1 and inhibit_o to 0 at once, without a clock edge, and wake_o stays 0.
- R10: In the cycle that wake_o is high, a sleep_en_i that is still 1 does not restart sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_en_i | input | 1 | Sleep-enable bit from the control register |
| cs_n_i | input | 1 | Chip select, active low |
| rx0_i | input | 1 | Receive line 0 (1 = recessive) |
| rx1_i | input | 1 | Receive line 1 (1 = recessive) |
| osc_en_o | output | 1 | Oscillator enable, 0 in sleep |
| inhibit_o | output | 1 | Activity inhibit, 1 while entering or in sleep |
| wake_o | output | 1 | One-cycle pulse on wake-up; clears the sleep bit |

## Verification
Each result has a fixed delay after its stimulus:

- Entry: inhibit_o follows two edges after sleep_en_i is raised, and osc_en_o falls one edge after that.
- Wake: three edges after a chip-select or receive stimulus, wake_o pulses and the outputs return to normal. Two edges of synchronisation and one of state update make up that delay.
- Reset: wake by reset needs no edge at all.

The bench changes inputs 1 ns after a rising edge and samples 1 ns after the edge at which each result is due. Where it matters, it also samples one edge earlier to confirm that the output has not yet changed.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    SWC_RUN       = 2'd0,
    SWC_HALT_PEND = 2'd1,
    SWC_ASLEEP    = 2'd2
  } swc_state_e;
endpackage

// File: rtl/swc_rst_sync.sv
module swc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/swc_sync_bit.sv
module swc_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/swc_wake_detect.sv
module swc_wake_detect #(
  parameter int NUM_RX      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [NUM_RX-1:0] rx,
  output logic              wake_req
);
  logic [NUM_RX-1:0] rx_s;
  logic [NUM_RX-1:0] rx_prev_q;
  logic [NUM_RX-1:0] fall;
  logic              cs_n_s;

  swc_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_n_s)
  );

  for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
    swc_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
      .clk(clk), .rst_n(rst_n), .d(rx[g]), .q(rx_s[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev_q[g] <= 1'b1;
      else        rx_prev_q[g] <= rx_s[g];
    end

    // recessive-to-dominant change only
    assign fall[g] = rx_prev_q[g] & ~rx_s[g];
  end

  assign wake_req = ~cs_n_s | (|fall);
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
  import swc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_en,
  input  logic wake_req,
  output logic osc_en,
  output logic inhibit,
  output logic wake
);
  swc_state_e state_q, state_d;
  logic       sleep_q;
  logic       wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      SWC_RUN: begin
        // bit must be high on two consecutive edges; no re-entry during wake pulse
        if (sleep_q && sleep_en && !wake_q) state_d = SWC_HALT_PEND;
      end
      SWC_HALT_PEND: begin
        if (wake_req) begin
          state_d = SWC_RUN;
          wake_d  = 1'b1;
        end else begin
          state_d = SWC_ASLEEP;
        end
      end
      SWC_ASLEEP: begin
        if (wake_req) begin
          state_d = SWC_RUN;
          wake_d  = 1'b1;
        end
      end
      default: state_d = SWC_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SWC_RUN;
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sleep_q <= sleep_en;
      wake_q  <= wake_d;
    end
  end

  assign inhibit = (state_q != SWC_RUN);
  assign osc_en  = (state_q != SWC_ASLEEP);
  assign wake    = wake_q;
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_en_i,
  input  logic cs_n_i,
  input  logic rx0_i,
  input  logic rx1_i,
  output logic osc_en_o,
  output logic inhibit_o,
  output logic wake_o
);
  localparam int NUM_RX = 2;

  logic              srst_n;
  logic              wake_req;
  logic [NUM_RX-1:0] rx_vec;

  assign rx_vec = {rx1_i, rx0_i};

  swc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  swc_wake_detect #(.NUM_RX(NUM_RX), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk(clk), .rst_n(srst_n), .cs_n(cs_n_i), .rx(rx_vec), .wake_req(wake_req)
  );

  swc_fsm u_fsm (
    .clk(clk), .rst_n(srst_n), .sleep_en(sleep_en_i), .wake_req(wake_req),
    .osc_en(osc_en_o), .inhibit(inhibit_o), .wake(wake_o)
  );
endmodule

// File: rtl/swc_checker.sv
module swc_checker (
  input logic clk,
  input logic rst_n,
  input logic sleep_en,
  input logic osc_en,
  input logic inhibit,
  input logic wake
);
  AST_OSC_OFF_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> inhibit); // R3

  AST_OSC_AFTER_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(inhibit)); // R3

  AST_ENTRY_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> ($past(sleep_en, 1) && $past(sleep_en, 2))); // R4

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake); // R5

  AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (osc_en && !inhibit && $past(inhibit))); // R5

  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !inhibit); // R10
endmodule

bind sleep_wake_ctrl swc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en_i),
  .osc_en(osc_en_o), .inhibit(inhibit_o), .wake(wake_o)
);

// File: tb/tb_sleep_wake_ctrl.sv
`timescale 1ns/100ps
module tb_sleep_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n, sleep_en, cs_n, rx0, rx1;
  logic osc_en, inhibit, wake;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_en_i(sleep_en), .cs_n_i(cs_n),
    .rx0_i(rx0), .rx1_i(rx1), .osc_en_o(osc_en), .inhibit_o(inhibit), .wake_o(wake)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go_sleep();
    sleep_en = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sleep_en = 1'b0; cs_n = 1'b1; rx0 = 1'b1; rx1 = 1'b1;
    tick(3);
    chk("R1", "osc_en", osc_en, 1'b1);
    chk("R1", "inhibit", inhibit, 1'b0);
    chk("R1", "wake", wake, 1'b0);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic t_idle();
    cs_n = 1'b0; rx0 = 1'b0;
    tick(5);
    chk("R2", "wake idle", wake, 1'b0);
    chk("R2", "inhibit idle", inhibit, 1'b0);
    chk("R2", "osc_en idle", osc_en, 1'b1);
    cs_n = 1'b1; rx0 = 1'b1;
    tick(4);
    chk("R2", "wake after release", wake, 1'b0);
  endtask

  task automatic t_glitch();
    sleep_en = 1'b1;
    tick(1);
    sleep_en = 1'b0;
    tick(5);
    chk("R4", "inhibit after pulse", inhibit, 1'b0);
    chk("R4", "osc_en after pulse", osc_en, 1'b1);
  endtask

  task automatic t_enter();
    sleep_en = 1'b1;
    tick(1);
    chk("R3", "inhibit after E1", inhibit, 1'b0);
    tick(1);
    chk("R3", "inhibit after E2", inhibit, 1'b1);
    chk("R3", "osc_en after E2", osc_en, 1'b1);
    tick(1);
    chk("R3", "osc_en after E3", osc_en, 1'b0);
    chk("R3", "inhibit after E3", inhibit, 1'b1);
  endtask

  // wake sequence check: source already driven, bit still high (R10)
  task automatic expect_wake(input string req);
    tick(2);
    chk(req, "inhibit before due edge", inhibit, 1'b1);
    chk(req, "wake before due edge", wake, 1'b0);
    tick(1);
    chk(req, "wake pulse", wake, 1'b1);
    chk(req, "inhibit on wake", inhibit, 1'b0);
    chk(req, "osc_en on wake", osc_en, 1'b1);
    tick(1);
    chk(req, "wake width", wake, 1'b0);
    chk("R10", "no re-entry", inhibit, 1'b0);
    sleep_en = 1'b0;
    tick(3);
    chk("R10", "still running", inhibit, 1'b0);
  endtask

  task automatic t_wake_cs();
    t_enter();
    cs_n = 1'b0;
    expect_wake("R5");
    cs_n = 1'b1;
    tick(3);
  endtask

  task automatic t_wake_rx0();
    go_sleep();
    rx0 = 1'b0;
    expect_wake("R6");
    rx0 = 1'b1;
    tick(4);
    chk("R6", "rise in run no wake", wake, 1'b0);
  endtask

  task automatic t_wake_rx1();
    go_sleep();
    rx1 = 1'b0;
    expect_wake("R7");
    rx1 = 1'b1;
    tick(4);
  endtask

  task automatic t_low_line();
    rx1 = 1'b0;
    tick(4);
    go_sleep();
    tick(8);
    chk("R8", "held low keeps sleep", osc_en, 1'b0);
    chk("R8", "held low no wake", wake, 1'b0);
    rx1 = 1'b1;
    tick(6);
    chk("R8", "rising keeps sleep", osc_en, 1'b0);
    chk("R8", "rising no wake", inhibit, 1'b1);
    cs_n = 1'b0;
    expect_wake("R5");
    cs_n = 1'b1;
    tick(3);
  endtask

  task automatic t_async_reset();
    go_sleep();
    chk("R9", "asleep before reset", osc_en, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk("R9", "osc_en async", osc_en, 1'b1);
    chk("R9", "inhibit async", inhibit, 1'b0);
    chk("R9", "wake on reset", wake, 1'b0);
    sleep_en = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(5);
    chk("R9", "running after reset", inhibit, 1'b0);
    chk("R9", "no wake after reset", wake, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_glitch();
    t_wake_cs();
    t_wake_rx0();
    t_wake_rx1();
    t_low_line();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule